// File: doc/BRIEF.md
# Paged Indirect Effective-Address Unit

This block turns a 12-bit memory-reference instruction into the absolute 12-bit address of its operand. The caller presents the instruction word and the address the instruction was fetched from, together with a one-cycle start strobe. A direct reference is resolved at once from the page-select bit and the 7-bit offset. An indirect reference reads one pointer word through a synchronous memory port, and that word becomes the effective address. When the pointer lives in the auto-index window of page zero (absolute addresses octal 0010 to 0017), the pointer is incremented, written back, and the incremented value is used.

The controller has five named states. IDLE waits for work. FINISH holds for one cycle while `done` is high, and it accepts a new start just as IDLE does. RD_REQ drives the pointer read. RD_TAKE captures the returned word. WR_BACK writes the incremented pointer. The transitions are: IDLE/FINISH to FINISH on a direct start; IDLE/FINISH to RD_REQ on an indirect start; FINISH to IDLE with no start; RD_REQ to RD_TAKE always; RD_TAKE to WR_BACK when the pointer address is in the window, otherwise to FINISH; WR_BACK to FINISH always. The memory port returns read data in the cycle after `mem_rd`, and it writes on the clock edge that ends a cycle with `mem_wr` high.

Top module: `ea_unit`

## Requirements
- R1: Instruction bit numbering has bit 0 as the most significant bit. Bit 3 (`instr[8]`) selects indirect, bit 4 (`instr[7]`) selects the page, and bits 5-11 (`instr[6:0]`) are the offset. With page select 0 the page address is `{5'b0, offset}`.
- R2: With page select 1 the page address is `{fetch_addr[11:7], offset}`, which is the page that holds the instruction.
- R3: With the indirect bit clear, `eff_addr` equals the page address and `done` is high in the first cycle after the start edge. No memory read or write is issued.
- R4: With the indirect bit set and the page address outside octal 0010-0017, exactly one read is made at the page address. The word returned is the effective address, with no second level of indirection. `done` is high in the third cycle after the start edge, and no write is made.
- R5: With the indirect bit set and the page address inside octal 0010-0017, one read and one write are made at that address. The written value and `eff_addr` are both the read word plus one. `done` is high in the fourth cycle after the start edge.
- R6: The auto-index increment wraps modulo 4096, so octal 7777 becomes 0000.
- R7: The window test uses the absolute page address. A current-page offset of octal 010-017 on a page other than zero does not auto-index. The same offset while executing on page zero does auto-index.
- R8: `busy` is high in RD_REQ, RD_TAKE and WR_BACK. A start that arrives while `busy` is high is ignored, and the result and timing of the reference in progress are unchanged.
- R9: `done` is a single-cycle pulse. `eff_addr` changes only in a cycle in which `done` is high, and it holds its value until the next completion.
- R10: After reset `busy`, `done`, `mem_rd` and `mem_wr` are 0 and `eff_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin resolving `instr` (accepted when not busy) |
| instr | input | 12 | Memory-reference instruction word |
| fetch_addr | input | 12 | Address the instruction was fetched from |
| busy | output | 1 | An indirect reference is in progress |
| done | output | 1 | One-cycle completion pulse |
| eff_addr | output | 12 | Resolved operand address |
| mem_addr | output | 12 | Pointer memory address |
| mem_rd | output | 1 | Pointer read request |
| mem_wr | output | 1 | Pointer write-back request |
| mem_wdata | output | 12 | Incremented pointer value |
| mem_rdata | input | 12 | Read data, valid the cycle after `mem_rd` |

## Verification
The hardest cases to reach are the edges of the auto-index decision. One is a pointer of 7777 in the window, which must wrap to zero. The others are the two current-page cases, which differ only in whether the fetch address lies on page zero. Random instructions seldom form these, so the stimulus places them directly: it loads the pointer words into the bench memory and chooses fetch addresses on page zero and on a higher page. Random traffic then biases about a third of its offsets into octal 010-017 and injects starts while the unit is busy.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_TAKE = 3'd2,
        ST_WR_BACK = 3'd3,
        ST_FINISH  = 3'd4
    } ea_state_t;

endpackage

// File: rtl/ea_page_form.sv
module ea_page_form #(
    parameter int AW    = 12,
    parameter int OFF_W = 7
) (
    input  logic [AW-1:0] instr,
    input  logic [AW-1:0] fetch_addr,
    output logic [AW-1:0] page_addr,
    output logic          is_indirect
);
    localparam int PG_BIT  = OFF_W;
    localparam int IND_BIT = OFF_W + 1;
    localparam int HI_W    = AW - OFF_W;

    logic [HI_W-1:0] page_hi;

    always_comb begin
        page_hi     = instr[PG_BIT] ? fetch_addr[AW-1:OFF_W] : '0;
        page_addr   = {page_hi, instr[OFF_W-1:0]};
        is_indirect = instr[IND_BIT];
    end

endmodule

// File: rtl/ea_autoinc.sv
module ea_autoinc #(
    parameter int          AW       = 12,
    parameter int          WIN_LOG2 = 3,
    parameter logic [11:0] WIN_BASE = 12'o0010
) (
    input  logic [AW-1:0] ptr_addr,
    input  logic [AW-1:0] ptr_word,
    output logic          in_window,
    output logic [AW-1:0] ptr_next
);
    localparam int TAG_W = AW - WIN_LOG2;
    localparam logic [AW-1:0] BASE_AW = AW'(WIN_BASE);
    localparam logic [TAG_W-1:0] WIN_TAG = BASE_AW[AW-1:WIN_LOG2];

    always_comb begin
        in_window = (ptr_addr[AW-1:WIN_LOG2] == WIN_TAG);
        ptr_next  = ptr_word + AW'(1);
    end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_indirect,
    input  logic in_window,
    output logic accept,
    output logic ld_direct,
    output logic ld_read,
    output logic ld_inc,
    output logic ld_incval,
    output logic busy,
    output logic done,
    output logic mem_rd,
    output logic mem_wr
);
    ea_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_FINISH: begin
                if (start) state_nx = is_indirect ? ST_RD_REQ : ST_FINISH;
                else       state_nx = ST_IDLE;
            end
            ST_RD_REQ:  state_nx = ST_RD_TAKE;
            ST_RD_TAKE: state_nx = in_window ? ST_WR_BACK : ST_FINISH;
            ST_WR_BACK: state_nx = ST_FINISH;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept    = 1'b0;
        ld_direct = 1'b0;
        ld_read   = 1'b0;
        ld_inc    = 1'b0;
        ld_incval = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        unique case (state)
            ST_IDLE, ST_FINISH: begin
                done      = (state == ST_FINISH);
                accept    = start;
                ld_direct = start && !is_indirect;
            end
            ST_RD_REQ: begin
                busy   = 1'b1;
                mem_rd = 1'b1;
            end
            ST_RD_TAKE: begin
                busy    = 1'b1;
                ld_inc  = in_window;
                ld_read = !in_window;
            end
            ST_WR_BACK: begin
                busy      = 1'b1;
                mem_wr    = 1'b1;
                ld_incval = 1'b1;
            end
            default: ;
        endcase
    end

    // R5
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R4
    read_then_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (busy && !mem_rd && !done));

    // R5
    write_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> done);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done || $past(start)));

endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
    parameter int          AW       = 12,
    parameter int          OFF_W    = 7,
    parameter int          WIN_LOG2 = 3,
    parameter logic [11:0] WIN_BASE = 12'o0010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] instr,
    input  logic [AW-1:0] fetch_addr,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata
);
    logic [AW-1:0] page_addr;
    logic          is_indirect;
    logic [AW-1:0] ptr_addr_q;
    logic [AW-1:0] inc_q;
    logic [AW-1:0] ptr_next;
    logic          in_window;
    logic          accept, ld_direct, ld_read, ld_inc, ld_incval;

    ea_page_form #(.AW(AW), .OFF_W(OFF_W)) u_form (
        .instr       (instr),
        .fetch_addr  (fetch_addr),
        .page_addr   (page_addr),
        .is_indirect (is_indirect)
    );

    ea_autoinc #(.AW(AW), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE)) u_inc (
        .ptr_addr  (ptr_addr_q),
        .ptr_word  (mem_rdata),
        .in_window (in_window),
        .ptr_next  (ptr_next)
    );

    ea_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .is_indirect (is_indirect),
        .in_window   (in_window),
        .accept      (accept),
        .ld_direct   (ld_direct),
        .ld_read     (ld_read),
        .ld_inc      (ld_inc),
        .ld_incval   (ld_incval),
        .busy        (busy),
        .done        (done),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_addr_q <= '0;
            inc_q      <= '0;
            eff_addr   <= '0;
        end else begin
            if (accept)    ptr_addr_q <= page_addr;
            if (ld_inc)    inc_q      <= ptr_next;
            if (ld_direct) eff_addr   <= page_addr;
            if (ld_read)   eff_addr   <= mem_rdata;
            if (ld_incval) eff_addr   <= inc_q;
        end
    end

    always_comb begin
        mem_addr  = ptr_addr_q;
        mem_wdata = inc_q;
    end

    // R5 R6
    wb_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == AW'($past(mem_rdata) + AW'(1))));

    // R5
    wb_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $stable(mem_addr));

    // R7
    wb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr[AW-1:WIN_LOG2] == WIN_BASE[AW-1:WIN_LOG2]));

    // R9
    eff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(eff_addr));

    // R5
    wb_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_wr) |-> (eff_addr == $past(mem_wdata)));

endmodule

// File: tb/ea_unit_tb.sv
module ea_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] instr = '0;
    logic [11:0] fetch_addr = '0;
    logic        busy, done, mem_rd, mem_wr;
    logic [11:0] eff_addr, mem_addr, mem_wdata;
    logic [11:0] mem_rdata = '0;
    logic [11:0] mem [4096];
    int          n_chk = 0;
    int          n_fail = 0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;

    always #5 clk = ~clk;

    ea_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .fetch_addr(fetch_addr), .busy(busy), .done(done),
        .eff_addr(eff_addr), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr];
            rd_cnt    <= rd_cnt + 1;
        end
        if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt        <= wr_cnt + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
        end
    endtask

    function automatic logic [11:0] form_addr(input logic [11:0] ins, input logic [11:0] pc);
        return ins[7] ? {pc[11:7], ins[6:0]} : {5'b0, ins[6:0]};
    endfunction

    task automatic run_op(input logic [11:0] ins, input logic [11:0] pc,
                          input bit poke, input string req);
        logic [11:0] pa, old, exp_eff;
        bit          ind, win;
        int          lat, cyc, r0, w0;
        pa      = form_addr(ins, pc);
        ind     = ins[8];
        win     = ind && (pa[11:3] == 9'o001);
        old     = mem[pa];
        exp_eff = !ind ? pa : (win ? 12'(old + 12'd1) : old);
        lat     = !ind ? 1 : (win ? 4 : 3);
        r0 = rd_cnt;
        w0 = wr_cnt;
        @(negedge clk);
        start = 1'b1; instr = ins; fetch_addr = pc;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        if (poke && ind) begin
            check({req, " R8 busy"}, int'(busy), 1);
            start = 1'b1; instr = ~ins; fetch_addr = ~pc;
        end
        while (!done && cyc < 12) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        start = 1'b0;
        check({req, " eff"}, int'(eff_addr), int'(exp_eff));
        check({req, " R3 R4 R5 latency"}, cyc, lat);
        check({req, " reads"}, rd_cnt - r0, ind ? 1 : 0);
        check({req, " writes"}, wr_cnt - w0, win ? 1 : 0);
        check({req, " R8 busy low at done"}, int'(busy), 0);
        if (win) check({req, " R5 writeback"}, int'(mem[pa]), int'(12'(old + 12'd1)));
    endtask

    initial begin
        logic [11:0] hold;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) mem[i] = 12'($urandom);
        repeat (3) @(negedge clk);
        check("R10 busy", int'(busy), 0);
        check("R10 done", int'(done), 0);
        check("R10 eff", int'(eff_addr), 0);
        check("R10 mem_rd", int'(mem_rd), 0);
        check("R10 mem_wr", int'(mem_wr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(12'o3150, 12'o4321, 0, "R1 page zero direct");
        run_op(12'o3350, 12'o4321, 0, "R2 current page direct");
        run_op(12'o1377, 12'o7777, 0, "R2 R3 top of memory");
        mem[12'o0500] = 12'o2100;
        run_op(12'o3700, 12'o0410, 0, "R4 indirect current page");
        mem[12'o0050] = 12'o2100;
        run_op(12'o3450, 12'o0410, 0, "R4 indirect page zero");
        mem[12'o0010] = 12'o0777;
        run_op(12'o1410, 12'o2000, 0, "R5 autoindex 0010");
        check("R5 stored 1000", int'(mem[12'o0010]), int'(12'o1000));
        run_op(12'o1410, 12'o2000, 0, "R5 autoindex repeat");
        check("R5 stored 1001", int'(mem[12'o0010]), int'(12'o1001));
        mem[12'o0017] = 12'o7777;
        run_op(12'o1417, 12'o3000, 0, "R6 wrap");
        check("R6 stored 0000", int'(mem[12'o0017]), 0);
        mem[12'o0007] = 12'o1234;
        run_op(12'o1407, 12'o3000, 0, "R7 below window");
        mem[12'o0020] = 12'o1234;
        run_op(12'o1420, 12'o3000, 0, "R7 above window");
        run_op(12'o1612, 12'o2400, 0, "R7 current page not window");
        run_op(12'o1612, 12'o0045, 0, "R7 page zero as current page");
        run_op(12'o1411, 12'o0600, 1, "R8 start while busy autoindex");
        run_op(12'o1533, 12'o0600, 1, "R8 start while busy indirect");

        hold = eff_addr;
        repeat (5) begin
            @(negedge clk);
            check("R9 done pulse", int'(done), 0);
            check("R9 eff held", int'(eff_addr), int'(hold));
        end

        for (int k = 0; k < 400; k++) begin
            logic [11:0] ins, pc;
            ins = 12'($urandom);
            pc  = 12'($urandom);
            if (($urandom % 3) == 0) ins[6:0] = 7'(8 + ($urandom % 8));
            if (($urandom % 4) == 0) pc[11:7] = 5'd0;
            if (($urandom % 5) == 0) mem[form_addr(ins, pc)] = 12'o7777;
            run_op(ins, pc, ($urandom % 4) == 0, "R1 R2 R4 R5 R7 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule